// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Probe

This block keeps 48 translation entries. Each entry maps an even/odd pair of virtual pages that share one virtual page-pair number (VPN2), one page-size mask and one address-space tag. Software does not reach the entries directly. It fills five staging words outside the block (page mask, entry high, entry low 0, entry low 1 and index), then issues one of three commands: an indexed write, an indexed read or a probe.

A write reduces the staged words to the fields a lookup needs: the 12-bit size mask, the masked VPN2, an 8-bit address-space tag, a global bit, two masked frame numbers, two valid flags and a scratchpad flag. A read returns the words as software should see them again. A probe compares one key against every entry at once. It reports the lowest matching entry number, or a miss code with bit 31 set. Along with the result it returns the frame fields of the entry that hit.

Commands arrive on a single port, at most one per cycle. Read data is ready one cycle after the command. A probe result is ready two cycles after the command and is marked by a one-cycle done strobe.

Top module: `assoc_tlb`

## Requirements
- R1: After reset every entry is all zero, rd_valid_o and probe_done_o are low, and every read-data and probe output is zero.
- R2: op_code 2'b00 with op_valid writes the staged words into the entry named by stage_index_i. The write takes effect at the next clock edge. An index of 48 to 63 changes no entry.
- R3: op_code 2'b01 with op_valid reads the entry named by stage_index_i[4:0]. rd_valid_o pulses one cycle later, and the data holds until the next read. The read returns the stored page mask, and entry high with the page-mask bits and bits [12:8] cleared.
- R4: The global bit of an entry is bit 0 of entry low 0 ANDed with bit 0 of entry low 1. A read returns both low words with bit 0 replaced by that global bit.
- R5: A probe key hits an entry when the masked VPN2 values match and either the entry is global or the key's bits [7:0] equal the entry's bits [7:0] of entry high.
- R6: The size mask is page mask bits [24:13]. Mask bit k clears VPN2 bit k, which is entry-high bit 13+k, in both the stored entry and the key.
- R7: When several entries hit, the probe reports the lowest entry number.
- R8: On a hit probe_index_o is the entry number with zeros above it. On a miss it is 32'h8000_0000.
- R9: op_code 2'b10 with op_valid starts a probe of stage_hi_i. probe_done_o is high for exactly one cycle, two cycles after the command.
- R10: A hit returns frame numbers taken from bits [25:6] of each low word with the mask bits cleared, valid flags from bit 1 of each low word, and a scratchpad flag from bit 31 of entry low 0. A miss returns zero for all of these.
- R11: A probe compares against the contents that exist when it is issued. A write issued in the following cycle does not change that probe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 2 | 00 write, 01 read, 10 probe, 11 none |
| stage_pmask_i | input | 32 | Staged page mask word |
| stage_hi_i | input | 32 | Staged entry high word, also the probe key |
| stage_lo0_i | input | 32 | Staged low word for the even page |
| stage_lo1_i | input | 32 | Staged low word for the odd page |
| stage_index_i | input | 6 | Staged entry number |
| rd_valid_o | output | 1 | Read data updated this cycle |
| rd_pmask_o | output | 32 | Read page mask |
| rd_hi_o | output | 32 | Read entry high |
| rd_lo0_o | output | 32 | Read low word, even page |
| rd_lo1_o | output | 32 | Read low word, odd page |
| probe_done_o | output | 1 | Probe result valid strobe |
| probe_index_o | output | 32 | Hit entry number or miss code |
| probe_pfn0_o | output | 20 | Even-page frame number of the hit entry |
| probe_pfn1_o | output | 20 | Odd-page frame number of the hit entry |
| probe_valid0_o | output | 1 | Even-page valid flag of the hit entry |
| probe_valid1_o | output | 1 | Odd-page valid flag of the hit entry |
| probe_spad_o | output | 1 | Scratchpad flag of the hit entry |

## Verification
A write is visible at the edge that samples it. Read data is due one edge after the read command. A probe result is due two edges after the probe command. The bench drives on falling edges and samples on the falling edge that follows the due edge. For each probe it also samples done one edge early and one edge late, to confirm it is a single pulse at exactly that cycle. The back-to-back case issues a write in the cycle after a probe. It compares that probe's result with the model state from before the write, which pins the compare to the probe's issue cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int TLB_ENTRIES = 48;
    localparam int WORD_W      = 32;
    localparam int MASK_W      = 12;
    localparam int MASK_LSB    = 13;
    localparam int VPN2_W      = WORD_W - MASK_LSB;
    localparam int ASID_W      = 8;
    localparam int PFN_LSB     = 6;
    localparam int PFN_W       = 20;
    localparam int WR_IDX_W    = 6;
    localparam int RD_IDX_W    = 5;
    localparam logic [WORD_W-1:0] HI_HOLE   = 32'h0000_1F00;
    localparam logic [WORD_W-1:0] MISS_CODE = 32'h8000_0000;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_PROBE = 2'b10,
        OP_NONE  = 2'b11
    } tlb_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] pmask;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo0;
        logic [WORD_W-1:0] lo1;
    } tlb_regs_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
    } tlb_key_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn0;
        logic [PFN_W-1:0] pfn1;
        logic             valid0;
        logic             valid1;
        logic             spad;
    } tlb_hit_info_t;

    typedef struct packed {
        tlb_regs_t     view;
        tlb_key_t      key;
        tlb_hit_info_t info;
    } tlb_entry_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
    } tlb_probe_key_t;

    function automatic logic [VPN2_W-1:0] vpn_keep(input logic [MASK_W-1:0] m);
        return ~{{(VPN2_W-MASK_W){1'b0}}, m};
    endfunction

    function automatic logic [PFN_W-1:0] pfn_keep(input logic [MASK_W-1:0] m);
        return ~{{(PFN_W-MASK_W){1'b0}}, m};
    endfunction

    // Reduce the staged words to stored fields; read-back words are
    // formed here once so that a read is a plain table lookup.
    function automatic tlb_entry_t build_entry(input tlb_regs_t s);
        tlb_entry_t e;
        logic [MASK_W-1:0] m;
        logic g;
        m = s.pmask[MASK_LSB +: MASK_W];
        g = s.lo0[0] & s.lo1[0];
        e.key.mask     = m;
        e.key.vpn2     = s.hi[WORD_W-1:MASK_LSB] & vpn_keep(m);
        e.key.asid     = s.hi[ASID_W-1:0];
        e.key.glob     = g;
        e.info.pfn0    = s.lo0[PFN_LSB +: PFN_W] & pfn_keep(m);
        e.info.pfn1    = s.lo1[PFN_LSB +: PFN_W] & pfn_keep(m);
        e.info.valid0  = s.lo0[1];
        e.info.valid1  = s.lo1[1];
        e.info.spad    = s.lo0[WORD_W-1];
        e.view.pmask   = s.pmask;
        e.view.hi      = s.hi & ~(s.pmask | HI_HOLE);
        e.view.lo0     = {s.lo0[WORD_W-1:1], g};
        e.view.lo1     = {s.lo1[WORD_W-1:1], g};
        return e;
    endfunction

    function automatic logic key_hit(input tlb_key_t k, input tlb_probe_key_t p);
        logic vpn_eq;
        vpn_eq = (k.vpn2 == (p.vpn2 & vpn_keep(k.mask)));
        return vpn_eq && (k.glob || (k.asid == p.asid));
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int DEPTH = TLB_ENTRIES,
    parameter int IDX_W = WR_IDX_W,
    parameter int RIDX_W = RD_IDX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_regs_t                 wr_regs,
    input  logic [RIDX_W-1:0]         rd_idx,
    output tlb_regs_t                 rd_regs,
    output tlb_key_t [DEPTH-1:0]      keys_o,
    output tlb_hit_info_t [DEPTH-1:0] info_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    tlb_entry_t table_q [DEPTH];
    tlb_entry_t built;

    assign built = build_entry(wr_regs);

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (rst) begin
                table_q[k] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                table_q[k] <= built;
            end
        end
    end

    assign rd_regs = table_q[rd_idx].view;

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign keys_o[g] = table_q[g].key;
        assign info_o[g] = table_q[g].info;
    end

    // R2: the top must never pass an out-of-range write strobe
    a_r2_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx <= LAST_IDX));

endmodule

// File: rtl/tlb_match_array.sv
module tlb_match_array
    import tlb_pkg::*;
#(
    parameter int DEPTH = TLB_ENTRIES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_i,
    input  tlb_probe_key_t       key_i,
    input  tlb_key_t [DEPTH-1:0] keys_i,
    output logic [DEPTH-1:0]     match_q,
    output logic                 valid_q
);

    logic [DEPTH-1:0] match_d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match_d[g] = key_hit(keys_i[g], key_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            match_q <= '0;
        end else begin
            valid_q <= issue_i;
            if (issue_i) begin
                match_q <= match_d;
            end
        end
    end

    // R9: first stage follows an issued probe by one edge
    a_r9_stage_follows: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> valid_q);

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit
    import tlb_pkg::*;
#(
    parameter int DEPTH = TLB_ENTRIES,
    parameter int IDX_W = WR_IDX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_i,
    input  logic [DEPTH-1:0]          match_i,
    input  tlb_hit_info_t [DEPTH-1:0] info_i,
    output logic                      done_o,
    output logic                      hit_o,
    output logic [WORD_W-1:0]         index_o,
    output tlb_hit_info_t             info_o
);

    logic             found;
    logic [IDX_W-1:0] sel;
    tlb_hit_info_t    sel_info;
    logic [IDX_W-1:0] idx_q;
    logic [DEPTH-1:0] below_sel;

    // Walk downward so the lowest matching entry is the last one taken.
    always_comb begin
        found    = 1'b0;
        sel      = '0;
        sel_info = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (match_i[k]) begin
                found    = 1'b1;
                sel      = IDX_W'(k);
                sel_info = info_i[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            hit_o   <= 1'b0;
            idx_q   <= '0;
            index_o <= '0;
            info_o  <= '0;
        end else begin
            done_o <= valid_i;
            if (valid_i) begin
                hit_o   <= found;
                idx_q   <= sel;
                index_o <= found ? {{(WORD_W-IDX_W){1'b0}}, sel} : MISS_CODE;
                info_o  <= sel_info;
            end
        end
    end

    assign below_sel = (DEPTH'(1) << idx_q) - DEPTH'(1);

    // R7: no lower-numbered entry matched the reported one
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (|match_i)) |=> ((($past(match_i)) & below_sel) == '0));

    // R7: the reported entry really matched
    a_r7_reported_matched: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (|match_i)) |=> (($past(match_i) >> idx_q) & DEPTH'(1)) != '0);

    // R8: hit flag reflects whether any comparator fired
    a_r8_hit_reflects_match: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (hit_o == $past(|match_i)));

endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb
    import tlb_pkg::*;
#(
    parameter int DEPTH = TLB_ENTRIES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [WORD_W-1:0]   stage_pmask_i,
    input  logic [WORD_W-1:0]   stage_hi_i,
    input  logic [WORD_W-1:0]   stage_lo0_i,
    input  logic [WORD_W-1:0]   stage_lo1_i,
    input  logic [WR_IDX_W-1:0] stage_index_i,
    output logic                rd_valid_o,
    output logic [WORD_W-1:0]   rd_pmask_o,
    output logic [WORD_W-1:0]   rd_hi_o,
    output logic [WORD_W-1:0]   rd_lo0_o,
    output logic [WORD_W-1:0]   rd_lo1_o,
    output logic                probe_done_o,
    output logic [WORD_W-1:0]   probe_index_o,
    output logic [PFN_W-1:0]    probe_pfn0_o,
    output logic [PFN_W-1:0]    probe_pfn1_o,
    output logic                probe_valid0_o,
    output logic                probe_valid1_o,
    output logic                probe_spad_o
);

    localparam int IDX_W = WR_IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    tlb_op_e        op;
    tlb_regs_t      stage;
    tlb_probe_key_t pkey;
    logic           wr_en;
    logic           rd_issue;
    logic           probe_issue;

    tlb_regs_t                 rd_regs_w;
    tlb_regs_t                 rd_regs_q;
    logic                      rd_valid_q;
    tlb_key_t [DEPTH-1:0]      keys_w;
    tlb_hit_info_t [DEPTH-1:0] info_w;
    logic [DEPTH-1:0]          match_w;
    logic                      match_valid_w;
    logic                      hit_w;
    tlb_hit_info_t             hit_info_w;

    assign op          = tlb_op_e'(op_code);
    assign stage       = '{pmask: stage_pmask_i, hi: stage_hi_i,
                           lo0: stage_lo0_i, lo1: stage_lo1_i};
    assign pkey        = '{vpn2: stage_hi_i[WORD_W-1:MASK_LSB],
                           asid: stage_hi_i[ASID_W-1:0]};
    assign wr_en       = op_valid && (op == OP_WRITE) && (stage_index_i <= LAST_IDX);
    assign rd_issue    = op_valid && (op == OP_READ);
    assign probe_issue = op_valid && (op == OP_PROBE);

    tlb_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RIDX_W(RD_IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (stage_index_i),
        .wr_regs (stage),
        .rd_idx  (stage_index_i[RD_IDX_W-1:0]),
        .rd_regs (rd_regs_w),
        .keys_o  (keys_w),
        .info_o  (info_w)
    );

    tlb_match_array #(.DEPTH(DEPTH)) u_match (
        .clk     (clk),
        .rst     (rst),
        .issue_i (probe_issue),
        .key_i   (pkey),
        .keys_i  (keys_w),
        .match_q (match_w),
        .valid_q (match_valid_w)
    );

    tlb_first_hit #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_first (
        .clk     (clk),
        .rst     (rst),
        .valid_i (match_valid_w),
        .match_i (match_w),
        .info_i  (info_w),
        .done_o  (probe_done_o),
        .hit_o   (hit_w),
        .index_o (probe_index_o),
        .info_o  (hit_info_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_regs_q  <= '0;
        end else begin
            rd_valid_q <= rd_issue;
            if (rd_issue) begin
                rd_regs_q <= rd_regs_w;
            end
        end
    end

    assign rd_valid_o     = rd_valid_q;
    assign rd_pmask_o     = rd_regs_q.pmask;
    assign rd_hi_o        = rd_regs_q.hi;
    assign rd_lo0_o       = rd_regs_q.lo0;
    assign rd_lo1_o       = rd_regs_q.lo1;
    assign probe_pfn0_o   = hit_info_w.pfn0;
    assign probe_pfn1_o   = hit_info_w.pfn1;
    assign probe_valid0_o = hit_info_w.valid0;
    assign probe_valid1_o = hit_info_w.valid1;
    assign probe_spad_o   = hit_info_w.spad;

    // R3: read data one edge after the command
    a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_issue |=> rd_valid_o);

    // R9: probe result two edges after the command
    a_r9_probe_latency: assert property (@(posedge clk) disable iff (rst)
        probe_issue |=> ##1 probe_done_o);

    // R10: a miss carries no frame fields
    a_r10_miss_clean: assert property (@(posedge clk) disable iff (rst)
        (probe_done_o && !hit_w) |-> (hit_info_w == '0));

    // R8: miss code on a miss, small entry number on a hit
    a_r8_index_code: assert property (@(posedge clk) disable iff (rst)
        probe_done_o |-> (hit_w ? (probe_index_o < WORD_W'(DEPTH))
                                : (probe_index_o == MISS_CODE)));

endmodule

// File: tb/assoc_tlb_tb_top.sv
module assoc_tlb_tb_top;
    import tlb_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_code;
    logic [31:0] s_pm, s_hi, s_lo0, s_lo1;
    logic [5:0]  s_idx;
    logic        rd_valid, p_done, p_v0, p_v1, p_sp;
    logic [31:0] rd_pm, rd_hi, rd_lo0, rd_lo1, p_index;
    logic [19:0] p_pfn0, p_pfn1;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [31:0] m_pm [48];
    logic [31:0] m_hi [48];
    logic [31:0] m_l0 [48];
    logic [31:0] m_l1 [48];

    always #5 clk = ~clk;

    assoc_tlb dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .stage_pmask_i(s_pm), .stage_hi_i(s_hi), .stage_lo0_i(s_lo0),
        .stage_lo1_i(s_lo1), .stage_index_i(s_idx),
        .rd_valid_o(rd_valid), .rd_pmask_o(rd_pm), .rd_hi_o(rd_hi),
        .rd_lo0_o(rd_lo0), .rd_lo1_o(rd_lo1),
        .probe_done_o(p_done), .probe_index_o(p_index),
        .probe_pfn0_o(p_pfn0), .probe_pfn1_o(p_pfn1),
        .probe_valid0_o(p_v0), .probe_valid1_o(p_v1), .probe_spad_o(p_sp)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] gen_hi(input int i);
        return {19'(32'h1000 + i * 4), 5'h15, 8'(i + 1)};
    endfunction
    function automatic logic [31:0] gen_pm(input int i);
        return (i % 7 == 3) ? 32'h0000_6000 : 32'h0;
    endfunction
    function automatic logic [31:0] gen_l0(input int i);
        return {1'(i % 4 == 1), 5'b10101, 20'(i * 123 + 7), 4'b0110,
                1'(i % 2 == 0), 1'(i % 5 == 0)};
    endfunction
    function automatic logic [31:0] gen_l1(input int i);
        return {1'b0, 5'b01010, 20'(i * 321 + 99), 4'b1001,
                1'(i % 3 != 0), 1'((i % 5 == 0) || (i % 3 == 0))};
    endfunction

    task automatic idle();
        op_valid = 1'b0;
        op_code  = 2'b11;
    endtask

    task automatic model_write(input logic [5:0] idx, input logic [31:0] pm,
                               input logic [31:0] hi, input logic [31:0] l0,
                               input logic [31:0] l1);
        if (idx < 6'd48) begin
            m_pm[idx] = pm; m_hi[idx] = hi; m_l0[idx] = l0; m_l1[idx] = l1;
        end
    endtask

    // Expected probe outcome from the requirement text (R5, R6, R7, R10).
    task automatic model_probe(input logic [31:0] key, output logic [31:0] e_idx,
                               output logic [19:0] e_p0, output logic [19:0] e_p1,
                               output logic [2:0] e_flags);
        logic [18:0] keep;
        logic g;
        e_idx = 32'h8000_0000; e_p0 = '0; e_p1 = '0; e_flags = '0;
        for (int i = 47; i >= 0; i--) begin
            keep = ~{7'b0, m_pm[i][24:13]};
            g    = m_l0[i][0] & m_l1[i][0];
            if (((m_hi[i][31:13] & keep) == (key[31:13] & keep)) &&
                (g || (m_hi[i][7:0] == key[7:0]))) begin
                e_idx   = 32'(i);
                e_p0    = m_l0[i][25:6] & keep;
                e_p1    = m_l1[i][25:6] & keep;
                e_flags = {m_l0[i][1], m_l1[i][1], m_l0[i][31]};
            end
        end
    endtask

    task automatic do_write(input logic [5:0] idx, input logic [31:0] pm,
                            input logic [31:0] hi, input logic [31:0] l0,
                            input logic [31:0] l1);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b00;
        s_idx = idx; s_pm = pm; s_hi = hi; s_lo0 = l0; s_lo1 = l1;
        @(negedge clk);
        idle();
        model_write(idx, pm, hi, l0, l1);
    endtask

    task automatic do_read(input logic [5:0] idx);
        int e;
        logic g;
        e = int'(idx[4:0]);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b01; s_idx = idx;
        @(negedge clk);
        idle();
        g = m_l0[e][0] & m_l1[e][0];
        chk("R3", "rd_valid", 32'(rd_valid), 32'd1);
        chk("R3", "rd_pmask", rd_pm, m_pm[e]);
        chk("R3", "rd_hi", rd_hi, m_hi[e] & ~(m_pm[e] | 32'h0000_1F00));
        chk("R4", "rd_lo0", rd_lo0, {m_l0[e][31:1], g});
        chk("R4", "rd_lo1", rd_lo1, {m_l1[e][31:1], g});
        @(negedge clk);
        chk("R3", "rd_valid pulse", 32'(rd_valid), 32'd0);
    endtask

    task automatic check_probe(input string req, input logic [31:0] e_idx,
                               input logic [19:0] e_p0, input logic [19:0] e_p1,
                               input logic [2:0] e_fl);
        chk("R9", "done due", 32'(p_done), 32'd1);
        chk(req, "probe_index", p_index, e_idx);
        chk("R10", "pfn0", 32'(p_pfn0), 32'(e_p0));
        chk("R10", "pfn1", 32'(p_pfn1), 32'(e_p1));
        chk("R10", "flags", 32'({p_v0, p_v1, p_sp}), 32'(e_fl));
    endtask

    task automatic do_probe(input string req, input logic [31:0] key);
        logic [31:0] e_idx;
        logic [19:0] e_p0, e_p1;
        logic [2:0]  e_fl;
        model_probe(key, e_idx, e_p0, e_p1, e_fl);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b10; s_hi = key;
        @(negedge clk);
        idle();
        chk("R9", "done early", 32'(p_done), 32'd0);
        @(negedge clk);
        check_probe(req, e_idx, e_p0, e_p1, e_fl);
        @(negedge clk);
        chk("R9", "done pulse", 32'(p_done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] e_idx;
        logic [19:0] e_p0, e_p1;
        logic [2:0]  e_fl;
        for (int i = 0; i < 48; i++) begin
            m_pm[i] = '0; m_hi[i] = '0; m_l0[i] = '0; m_l1[i] = '0;
        end
        idle();
        s_pm = '0; s_hi = '0; s_lo0 = '0; s_lo1 = '0; s_idx = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R1", "probe_done", 32'(p_done), 32'd0);
        chk("R1", "probe_index", p_index, 32'd0);
        chk("R1", "rd_hi", rd_hi, 32'd0);
        chk("R1", "probe_pfn0", 32'(p_pfn0), 32'd0);
        do_read(6'd7);
        do_probe("R1", 32'h0);

        // R2: fill every entry
        for (int i = 0; i < 48; i++) begin
            do_write(6'(i), gen_pm(i), gen_hi(i), gen_l0(i), gen_l1(i));
        end
        // R3, R4: read back the reachable range, and the 5-bit wrap
        for (int i = 0; i < 32; i++) do_read(6'(i));
        do_read(6'd37);
        do_read(6'd63);

        // R5, R8, R10: exact keys all hit their own entry
        for (int i = 0; i < 48; i++) do_probe("R8", gen_hi(i));
        // R5: wrong tag hits only global entries
        for (int i = 0; i < 48; i++) do_probe("R5", gen_hi(i) ^ 32'h0000_0080);
        // R5: bits [12:8] of the key take no part
        do_probe("R5", gen_hi(9) ^ 32'h0000_1F00);
        // R6: low VPN2 bit differs, only masked entries still hit
        for (int i = 0; i < 48; i++) do_probe("R6", gen_hi(i) + 32'h0000_2000);

        // R7: duplicate keys, lowest number wins
        do_write(6'd30, gen_pm(10), gen_hi(10), gen_l0(10), gen_l1(10));
        do_probe("R7", gen_hi(10));
        do_write(6'd10, 32'h0, {19'h7D000, 5'h0, 8'h44}, 32'h0000_0042, 32'h0);
        do_probe("R7", gen_hi(10));

        // R2: out-of-range writes change nothing
        do_write(6'd48, 32'h0, {19'h7F000, 5'h0, 8'h01}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_write(6'd55, 32'h0, {19'h7F004, 5'h0, 8'h01}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_write(6'd63, 32'h0, {19'h7F008, 5'h0, 8'h01}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_probe("R2", {19'h7F000, 5'h0, 8'h01});
        do_probe("R2", {19'h7F004, 5'h0, 8'h01});
        do_probe("R2", {19'h7F008, 5'h0, 8'h01});
        do_read(6'd16);

        // R11: write in the cycle after a probe does not leak into it
        model_probe(gen_hi(5), e_idx, e_p0, e_p1, e_fl);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b10; s_hi = gen_hi(5);
        @(negedge clk);
        op_code = 2'b00; s_idx = 6'd5; s_pm = 32'h0;
        s_hi = {19'h7E000, 5'h0, 8'h06}; s_lo0 = 32'h0000_0FC2; s_lo1 = 32'h0;
        @(negedge clk);
        idle();
        model_write(6'd5, 32'h0, {19'h7E000, 5'h0, 8'h06}, 32'h0000_0FC2, 32'h0);
        check_probe("R11", e_idx, e_p0, e_p1, e_fl);
        do_probe("R11", gen_hi(5));
        do_probe("R11", {19'h7E000, 5'h0, 8'h06});

        // R8: key absent everywhere
        do_probe("R8", 32'hFFFF_E0AA);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule